// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer Counter

This block is a timer core built around a 16-bit counter. It picks one of four clock-enable inputs, divides the chosen enable through two prescaler stages, and moves the counter on each divided tick. A 2-bit mode input selects how the counter moves: it can hold, count up to a programmable period and return to zero, count freely through the whole 16-bit range, or run up to the period and back down to zero.

Two sticky flags record events. One marks the count reaching the period value. The other marks the wrap event of the active mode. Software clears each flag by pulsing its acknowledge input. The interrupt output follows the wrap flag when interrupts are enabled.

The period register and the counter can both be written while the timer runs. A single-cycle clear pulse resets the counter, both prescaler stages and the up/down direction. Everything runs on one system clock, and each clock source arrives as a one-cycle enable.

Top module: `mm_timer`

## Requirements
- R1: After reset the count, the period register, the direction output and both flags read 0, and the interrupt output is 0.
- R2: `src_sel_i` selects bit `src_sel_i` of `src_tick_i` as the source enable. The first prescaler stage passes one enable in every 2^`pre_sel_i` source enables (so 1, 2, 4 or 8).
- R3: The second prescaler stage passes one in every `post_sel_i`+1 outputs of the first stage. The counter moves only on these final ticks. With the source held high, `pre_sel_i`=2 and `post_sel_i`=2, the count advances once every 12 cycles.
- R4: Mode 2'b00 holds the count and the direction on every tick.
- R5: Mode 2'b01 counts 0,1,…,P and returns to 0, where P is the period register, so one period is P+1 ticks. A tick with the count already above P sends it to 0. The wrap flag is set only when the count steps from exactly P to 0.
- R6: Mode 2'b10 counts up through the full range. The step from 0xFFFF to 0 sets the wrap flag.
- R7: Mode 2'b11 counts up to P and then down to 0. The step onto 0 while counting down sets the wrap flag and turns the direction back up. `down_o` is 1 while the counter is descending. A stop and restart continues from the held count and direction.
- R8: In mode 2'b11, changing the period while descending does not stop the descent. The counter reaches 0 first, and the new period governs the next rise.
- R9: A `clr_i` pulse sets the count to 0, the direction to up, and both prescaler stages to their first state. The first tick after the clear comes a full divided interval later. `clr_i` wins over a counter write in the same cycle.
- R10: The match flag is set on a tick that moves the count up by one onto a value equal to the period register.
- R11: A flag whose set event and acknowledge pulse come in the same cycle ends up set. Otherwise an acknowledge clears the flag. `irq_o` is 1 exactly when the wrap flag and `irq_en_i` are both 1.
- R12: A `cnt_wr_i` pulse loads `cnt_data_i` into the counter and overrides a tick in that cycle. A `per_wr_i` pulse loads the period register, which takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick_i | input | 4 | Four single-cycle clock-source enables |
| src_sel_i | input | 2 | Source enable select |
| pre_sel_i | input | 2 | First-stage divide select (1,2,4,8) |
| post_sel_i | input | 3 | Second-stage divide, value n divides by n+1 |
| mode_i | input | 2 | 00 hold, 01 up, 10 continuous, 11 up/down |
| clr_i | input | 1 | Clear pulse for counter, prescaler and direction |
| irq_en_i | input | 1 | Wrap interrupt enable |
| per_wr_i | input | 1 | Period register write strobe |
| per_data_i | input | 16 | Period write value |
| cnt_wr_i | input | 1 | Counter write strobe |
| cnt_data_i | input | 16 | Counter write value |
| wrap_ack_i | input | 1 | Clears the wrap flag |
| match_ack_i | input | 1 | Clears the match flag |
| count_o | output | 16 | Current count |
| period_o | output | 16 | Period register |
| down_o | output | 1 | 1 while counting down |
| wrap_flag_o | output | 1 | Sticky wrap flag |
| match_flag_o | output | 1 | Sticky period-match flag |
| irq_o | output | 1 | Wrap flag gated by enable |

## Verification
The embedded properties check the local rules on every cycle. They cover the hold in mode 00 with its preserved direction, the return to 0 in up mode from a count at or above the period, the wrap flag on the 0xFFFF rollover, the full effect of a clear, and acknowledge behaviour. Prescaler intervals, the turnaround points of the up/down mode, and a descent that continues after a period change all span many cycles. Only the bench scenarios show those, comparing each cycle against an independent model and adding directed sequences with known counts.

// File: rtl/mm_timer.sv
module mm_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    src_tick_i,
  input  logic [1:0]    src_sel_i,
  input  logic [1:0]    pre_sel_i,
  input  logic [2:0]    post_sel_i,
  input  logic [1:0]    mode_i,
  input  logic          clr_i,
  input  logic          irq_en_i,
  input  logic          per_wr_i,
  input  logic [CW-1:0] per_data_i,
  input  logic          cnt_wr_i,
  input  logic [CW-1:0] cnt_data_i,
  input  logic          wrap_ack_i,
  input  logic          match_ack_i,
  output logic [CW-1:0] count_o,
  output logic [CW-1:0] period_o,
  output logic          down_o,
  output logic          wrap_flag_o,
  output logic          match_flag_o,
  output logic          irq_o
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TOP = '1;

  logic [2:0]    pre_q, post_q, pre_lim;
  logic [CW-1:0] cnt_q, per_q, cnt_nxt;
  logic          dir_q, dir_nxt, wrap_q, match_q;
  logic          sel_en, stage1, tick, w_set, m_set, ev_ok;

  assign sel_en  = src_tick_i[src_sel_i];
  assign pre_lim = 3'((1 << pre_sel_i) - 1);
  assign stage1  = sel_en && (pre_q == pre_lim);
  assign tick    = stage1 && (post_q == post_sel_i);
  assign ev_ok   = !clr_i && !cnt_wr_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_q  <= '0;
      post_q <= '0;
    end else if (clr_i) begin
      pre_q  <= '0;
      post_q <= '0;
    end else begin
      if (sel_en) pre_q  <= stage1 ? 3'd0 : pre_q + 3'd1;
      if (stage1) post_q <= tick ? 3'd0 : post_q + 3'd1;
    end

  always_comb begin
    cnt_nxt = cnt_q;
    dir_nxt = dir_q;
    w_set   = 1'b0;
    m_set   = 1'b0;
    if (tick) begin
      case (mode_i)
        2'b01:
          if (cnt_q >= per_q) begin
            cnt_nxt = '0;
            w_set   = (cnt_q == per_q);
          end else begin
            cnt_nxt = cnt_q + ONE;
            m_set   = (cnt_nxt == per_q);
          end
        2'b10: begin
          cnt_nxt = cnt_q + ONE;
          w_set   = (cnt_q == TOP);
          m_set   = (cnt_q != TOP) && (cnt_nxt == per_q);
        end
        2'b11:
          if (dir_q) begin
            if (cnt_q == '0) dir_nxt = 1'b0;
            else begin
              cnt_nxt = cnt_q - ONE;
              if (cnt_q == ONE) begin
                w_set   = 1'b1;
                dir_nxt = 1'b0;
              end
            end
          end else if (cnt_q < per_q) begin
            cnt_nxt = cnt_q + ONE;
            m_set   = (cnt_nxt == per_q);
          end else if (cnt_q != '0) begin
            cnt_nxt = cnt_q - ONE;
            dir_nxt = 1'b1;
            if (cnt_q == ONE) begin
              w_set   = 1'b1;
              dir_nxt = 1'b0;
            end
          end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q   <= '0;
      dir_q   <= 1'b0;
      per_q   <= '0;
      wrap_q  <= 1'b0;
      match_q <= 1'b0;
    end else begin
      if (clr_i) begin
        cnt_q <= '0;
        dir_q <= 1'b0;
      end else if (cnt_wr_i) begin
        cnt_q <= cnt_data_i;
      end else begin
        cnt_q <= cnt_nxt;
        dir_q <= dir_nxt;
      end
      if (per_wr_i) per_q <= per_data_i;
      wrap_q  <= (w_set && ev_ok) || (wrap_q && !wrap_ack_i);
      match_q <= (m_set && ev_ok) || (match_q && !match_ack_i);
    end

  assign count_o      = cnt_q;
  assign period_o     = per_q;
  assign down_o       = dir_q;
  assign wrap_flag_o  = wrap_q;
  assign match_flag_o = match_q;
  assign irq_o        = wrap_q & irq_en_i;

  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 && ev_ok) |=> ($stable(count_o) && $stable(down_o)));

  // R5
  up_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode_i == 2'b01 && cnt_q >= per_q && ev_ok) |=> (count_o == '0));

  // R6
  cont_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode_i == 2'b10 && cnt_q == TOP && ev_ok) |=> wrap_flag_o);

  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_o == '0 && !down_o && pre_q == 3'd0 && post_q == 3'd0));

  // R11
  wrap_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_ack_i && !(tick && mode_i != 2'b00)) |=> !wrap_flag_o);

  // R12
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr_i && !clr_i) |=> (count_o == $past(cnt_data_i)));
endmodule

// File: tb/mm_timer_bench.sv
module mm_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] src_tick = '0;
  logic [1:0] src_sel = '0, pre_sel = '0, mode = '0;
  logic [2:0] post_sel = '0;
  logic clr = 0, irq_en = 0, per_wr = 0, cnt_wr = 0, wrap_ack = 0, match_ack = 0;
  logic [15:0] per_data = '0, cnt_data = '0;
  logic [15:0] count, period;
  logic down, wrap_f, match_f, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [2:0]  m_pre = '0, m_post = '0;
  logic [15:0] m_cnt = '0, m_per = '0;
  logic m_dir = 0, m_wrap = 0, m_match = 0;

  always #10 clk = ~clk;

  mm_timer u_mm_timer (
    .clk(clk), .rst_n(rst_n), .src_tick_i(src_tick), .src_sel_i(src_sel),
    .pre_sel_i(pre_sel), .post_sel_i(post_sel), .mode_i(mode), .clr_i(clr),
    .irq_en_i(irq_en), .per_wr_i(per_wr), .per_data_i(per_data),
    .cnt_wr_i(cnt_wr), .cnt_data_i(cnt_data), .wrap_ack_i(wrap_ack),
    .match_ack_i(match_ack), .count_o(count), .period_o(period),
    .down_o(down), .wrap_flag_o(wrap_f), .match_flag_o(match_f), .irq_o(irq));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic st, t1, tk, ws, ms, nd, ok;
    logic [2:0] lim;
    logic [15:0] nx;
    st = src_tick[src_sel];
    lim = 3'((1 << pre_sel) - 1);
    t1 = st && (m_pre == lim);
    tk = t1 && (m_post == post_sel);
    if (clr) begin m_pre = 0; m_post = 0; end
    else begin
      if (st) m_pre = t1 ? 3'd0 : m_pre + 3'd1;
      if (t1) m_post = tk ? 3'd0 : m_post + 3'd1;
    end
    nx = m_cnt; nd = m_dir; ws = 0; ms = 0;
    if (tk && mode == 2'b01) begin
      if (m_cnt > m_per) nx = 0;
      else if (m_cnt == m_per) begin nx = 0; ws = 1; end
      else begin nx = m_cnt + 1; ms = (nx == m_per); end
    end else if (tk && mode == 2'b10) begin
      nx = m_cnt + 1; ws = (m_cnt == 16'hFFFF); ms = !ws && (nx == m_per);
    end else if (tk && mode == 2'b11) begin
      if (!m_dir && m_cnt < m_per) begin nx = m_cnt + 1; ms = (nx == m_per); end
      else if (m_cnt == 0) nd = 0;
      else begin
        nx = m_cnt - 1; nd = 1;
        if (nx == 0) begin ws = 1; nd = 0; end
      end
    end
    ok = !clr && !cnt_wr;
    if (clr) begin m_cnt = 0; m_dir = 0; end
    else if (cnt_wr) m_cnt = cnt_data;
    else begin m_cnt = nx; m_dir = nd; end
    m_wrap  = (ws && ok) || (m_wrap && !wrap_ack);
    m_match = (ms && ok) || (m_match && !match_ack);
    if (per_wr) m_per = per_data;
  endtask

  task automatic compare_all();
    string tg;
    case (mode)
      2'b00: tg = "R4"; 2'b01: tg = "R5"; 2'b10: tg = "R6"; default: tg = "R7";
    endcase
    check(count == m_cnt, {tg, " count"}, count, m_cnt);
    check(down == m_dir, "R7 direction", down, m_dir);
    check(wrap_f == m_wrap, "R11 wrap flag", wrap_f, m_wrap);
    check(match_f == m_match, "R10 match flag", match_f, m_match);
    check(irq == (m_wrap && irq_en), "R11 irq", irq, m_wrap && irq_en);
    check(period == m_per, "R12 period", period, m_per);
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    clr = 0; per_wr = 0; cnt_wr = 0; wrap_ack = 0; match_ack = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic finish_run();
    if (done) return;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(count == 0 && period == 0 && !down && !wrap_f && !match_f && !irq,
          "R1 reset state", count, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3: held source, divide 4 then 3 -> one step per 12 cycles
    src_sel = 2; src_tick = 4'b0100; pre_sel = 2; post_sel = 2; mode = 2'b10;
    clr = 1; cycle();
    run(119);
    check(count == 9, "R2 R3 prescaled count", count, 9);
    run(1);
    check(count == 10, "R2 R3 prescaled count", count, 10);

    // R5 R10 R11: up mode period 4
    src_sel = 0; src_tick = 4'b0001; pre_sel = 0; post_sel = 0; mode = 2'b01;
    irq_en = 1; per_wr = 1; per_data = 4; clr = 1; wrap_ack = 1; match_ack = 1;
    cycle();
    run(4);
    check(count == 4 && match_f, "R10 match at period", count, 4);
    run(1);
    check(count == 0 && wrap_f && irq, "R5 wrap to zero", count, 0);
    wrap_ack = 1; cycle();
    check(!wrap_f && !irq, "R11 ack clears", wrap_f, 0);
    cnt_wr = 1; cnt_data = 100; cycle();
    check(count == 100, "R12 counter load", count, 100);
    run(1);
    check(count == 0 && !wrap_f, "R5 above period", count, 0);

    // R6 continuous rollover
    mode = 2'b10; cnt_wr = 1; cnt_data = 16'hFFFE; cycle();
    run(2);
    check(count == 0 && wrap_f, "R6 rollover", count, 0);

    // R7 up/down period 3, stop while descending
    wrap_ack = 1; per_wr = 1; per_data = 3; cycle();
    mode = 2'b11; clr = 1; cycle();
    run(4);
    check(count == 2 && down, "R7 descending", count, 2);
    mode = 2'b00; run(5);
    check(count == 2 && down, "R7 held in stop", count, 2);
    mode = 2'b11; run(2);
    check(count == 0 && wrap_f && !down, "R7 bottom wrap", count, 0);

    // R9 clear during descent resets direction and prescaler
    run(4);
    check(down, "R7 descending again", down, 1);
    pre_sel = 2; clr = 1; cycle();
    check(count == 0 && !down, "R9 clear", count, 0);
    run(3);
    check(count == 0, "R9 prescaler restarted", count, 0);
    run(1);
    check(count == 1, "R9 first tick", count, 1);
    pre_sel = 0;

    // R8 period shrink while descending
    per_wr = 1; per_data = 10; clr = 1; cycle();
    run(12);
    check(count == 8 && down, "R8 before change", count, 8);
    per_wr = 1; per_data = 3; cycle();
    check(count == 7 && down, "R8 keeps descending", count, 7);
    run(7);
    check(count == 0 && !down, "R8 reached zero", count, 0);
    run(3);
    check(count == 3, "R8 new period peak", count, 3);

    // R9 R12 priority
    cnt_wr = 1; cnt_data = 55; clr = 1; cycle();
    check(count == 0, "R9 clear over load", count, 0);
    mode = 2'b01; per_wr = 1; per_data = 500; cycle();
    cnt_wr = 1; cnt_data = 77; cycle();
    check(count == 77, "R12 load over tick", count, 77);

    // random phase
    for (int i = 0; i < 40000; i++) begin
      src_tick = 4'($urandom);
      if (i % 300 == 0) begin
        src_sel = 2'($urandom); mode = 2'($urandom);
        pre_sel = ($urandom % 4 == 0) ? 2'($urandom) : 2'd0;
        post_sel = ($urandom % 4 == 0) ? 3'($urandom) : 3'd0;
        irq_en = 1'($urandom);
      end
      if ($urandom % 100 == 0) clr = 1;
      if ($urandom % 150 == 0) begin
        cnt_wr = 1; cnt_data = ($urandom % 2) ? 16'($urandom % 50) : 16'($urandom);
      end
      if ($urandom % 120 == 0) begin
        per_wr = 1; per_data = ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 40);
      end
      wrap_ack = ($urandom % 8 == 0);
      match_ack = ($urandom % 8 == 0);
      cycle();
    end
    finish_run();
  end
endmodule